// File: doc/BRIEF.md
# Ethernet Transmit Event Interrupt Controller

This block sits beside the transmit path of a 10/100 Ethernet MAC and turns transmit conditions into sticky status bits and a single maskable interrupt line. It follows each packet from its start strobe to its end. While a packet is in progress it counts collisions, measures how many bit times the frame has been on the wire, and times deferral against the bit rate. The bit time is derived from a base tick. At the fast rate every base tick is one bit time. At the slow rate every `SLOW_DIV`-th base tick is one bit time.

A transmit engine state machine controls the DMA side. It has three states: `ENG_RUN`, `ENG_STOP` and `ENG_HALT`.
- `ENG_RUN -> ENG_HALT` on a bus error.
- `ENG_RUN -> ENG_STOP` when a descriptor fetch finds a descriptor the DMA does not own.
- `ENG_STOP -> ENG_RUN` on a start-demand write.
- `ENG_STOP -> ENG_HALT` on a bus error.
- `ENG_HALT` is left only through a software reset.
- A software reset returns the engine to `ENG_RUN` from any state.

A packet tracker state machine has two states, `TRK_IDLE` and `TRK_BUSY`.
- `TRK_IDLE -> TRK_BUSY` on a packet start.
- `TRK_BUSY -> TRK_BUSY` on a new packet start, which restarts the tracking.
- `TRK_BUSY -> TRK_IDLE` on packet done or on an abort.
- `TRK_BUSY -> TRK_IDLE` on a software reset.

Software programs an 8-bit enable field and reads the enable and status words. It clears status bits by writing ones to them, and issues start-demand writes and software resets. Both the enable word and the status word carry the event field at bits 24:17.

Top module: `tx_evt_irq`

## Requirements
- R1: After reset the enable word and the status word read 0, `irq` is 0, and `tx_halt` and `tx_stop` are 0.
- R2: A status bit is set by its event whatever the enables hold. It stays set until a clear write with a 1 in that position. Ones in other positions do not clear it. An event in the same cycle as a clear write leaves the bit set.
- R3: `en_wr` loads `wr_field` into enable bits 24:17 of the enable word. `irq` equals the OR over bits 24:17 of (status AND enable).
- R4: A bus error sets status bit 24 and puts the engine in `ENG_HALT` (`tx_halt`=1). A start-demand write does not release it. Only `sw_reset` returns the engine to `ENG_RUN`, and that reset does not clear the status.
- R5: A descriptor fetch with `desc_owned`=0 in `ENG_RUN` sets status bit 23 and enters `ENG_STOP` (`tx_stop`=1). A fetch with `desc_owned`=1 does neither. `ENG_STOP` holds until a start-demand write.
- R6: A collision in a packet after at least `LATE_BITS` bit times of non-deferring transmission sets status bit 22. An earlier collision does not.
- R7: The `ABORT_COLL`-th collision of one packet sets status bit 21 and ends the packet.
- R8: At the end of a packet, status bit 20 is set if `carrier` was never high since the packet started.
- R9: Status bit 19 is set on the bit time that takes deferral within a packet beyond `DEFER_BITS` bit times, and not before.
- R10: Status bit 18 is set once per packet, at `pkt_done` or at an abort.
- R11: `fifo_underflow` sets status bit 17 only while a packet is in progress.
- R12: With `spd_10m`=0 each base tick is one bit time. With `spd_10m`=1 only every `SLOW_DIV`-th base tick is one bit time.
- R13: `pkt_start` clears the collision count, the frame bit count and the defer timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Software reset strobe for the engine and the tracker |
| base_tick | input | 1 | Bit-rate tick at the fast rate |
| spd_10m | input | 1 | 1 selects the slow rate |
| pkt_start | input | 1 | Start-of-packet strobe |
| pkt_done | input | 1 | Packet sent or discarded strobe |
| collision | input | 1 | Collision strobe |
| carrier | input | 1 | Carrier sense level |
| deferring | input | 1 | MAC is deferring |
| fifo_underflow | input | 1 | Transmit FIFO underflow strobe |
| dma_fetch | input | 1 | DMA descriptor fetch strobe |
| desc_owned | input | 1 | Fetched descriptor is owned by the DMA |
| dma_bus_err | input | 1 | System bus error strobe from the DMA |
| start_dmd_wr | input | 1 | Start-demand register write |
| en_wr | input | 1 | Enable field write |
| stat_clr_wr | input | 1 | Status write-one-to-clear |
| wr_field | input | 8 | Write data for the event field (bit 7 = word bit 24) |
| en_rdata | output | 32 | Enable word, field at 24:17 |
| stat_rdata | output | 32 | Status word, field at 24:17 |
| irq | output | 1 | Interrupt request |
| tx_halt | output | 1 | Engine is in `ENG_HALT` |
| tx_stop | output | 1 | Engine is in `ENG_STOP` |

## Verification
Every event registers into the status word on the first rising edge after the cycle in which its inputs are presented. `irq`, `tx_halt` and `tx_stop` change on that same edge, because they decode registered state directly. The bench changes inputs just after a falling edge, lets exactly one rising edge pass, and samples at the following falling edge. Each result is therefore checked one clock after its cause. The threshold sweeps (late-collision position at both rates, collision count, defer length) compute the expected bit arithmetically from the sweep index.

// File: rtl/tx_evt_pkg.sv
package tx_evt_pkg;

    localparam int unsigned EVT_LO = 17;
    localparam int unsigned EVT_N  = 8;

    // Packed so that bus_err lands at field bit 7 (word bit 24)
    typedef struct packed {
        logic bus_err;
        logic desc;
        logic late;
        logic abort;
        logic nocrs;
        logic defer;
        logic done;
        logic underrun;
    } evt_vec_t;

    typedef enum logic [1:0] {
        ENG_RUN  = 2'd0,
        ENG_STOP = 2'd1,
        ENG_HALT = 2'd2
    } eng_state_e;

    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_BUSY = 1'b1
    } trk_state_e;

endpackage

// File: rtl/tx_bit_pacer.sv
module tx_bit_pacer #(
    parameter int unsigned SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_tick,
    input  logic spd_slow,
    output logic bit_stb
);
    localparam int unsigned DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(SLOW_DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (!spd_slow)
            div_q <= '0;
        else if (base_tick)
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end

    always_comb bit_stb = base_tick && (!spd_slow || div_q == LAST);

endmodule

// File: rtl/tx_pkt_tracker.sv
module tx_pkt_tracker
    import tx_evt_pkg::*;
#(
    parameter int unsigned ABORT_COLL = 16,
    parameter int unsigned LATE_BITS  = 512,
    parameter int unsigned DEFER_BITS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_reset,
    input  logic bit_stb,
    input  logic pkt_start,
    input  logic pkt_done,
    input  logic collision,
    input  logic carrier,
    input  logic deferring,
    input  logic fifo_underflow,
    output logic ev_late,
    output logic ev_abort,
    output logic ev_nocrs,
    output logic ev_defer,
    output logic ev_done,
    output logic ev_underrun
);
    localparam int unsigned CW = $clog2(ABORT_COLL + 1);
    localparam int unsigned FW = $clog2(LATE_BITS + 1);
    localparam int unsigned TW = $clog2(DEFER_BITS + 1);

    trk_state_e     st_q, st_d;
    logic [CW-1:0]  coll_q;
    logic [FW-1:0]  frm_q;
    logic [TW-1:0]  dfr_q;
    logic           dfr_flag_q;
    logic           crs_seen_q;
    logic           busy, coll_hit, end_pkt;

    always_comb begin
        busy        = (st_q == TRK_BUSY) && !pkt_start && !sw_reset;
        coll_hit    = busy && collision;
        ev_late     = coll_hit && (frm_q == FW'(LATE_BITS));
        ev_abort    = coll_hit && (coll_q == CW'(ABORT_COLL - 1));
        end_pkt     = busy && (pkt_done || ev_abort);
        ev_done     = end_pkt;
        ev_nocrs    = end_pkt && !crs_seen_q && !carrier;
        ev_defer    = busy && deferring && bit_stb && !dfr_flag_q
                      && (dfr_q == TW'(DEFER_BITS));
        ev_underrun = busy && fifo_underflow;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (sw_reset)
            st_d = TRK_IDLE;
        else if (pkt_start)
            st_d = TRK_BUSY;
        else begin
            unique case (st_q)
                TRK_IDLE: st_d = TRK_IDLE;
                TRK_BUSY: if (end_pkt) st_d = TRK_IDLE;
                default:  st_d = TRK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= TRK_IDLE;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coll_q     <= '0;
            frm_q      <= '0;
            dfr_q      <= '0;
            dfr_flag_q <= 1'b0;
            crs_seen_q <= 1'b0;
        end else if (sw_reset || pkt_start) begin
            coll_q     <= '0;
            frm_q      <= '0;
            dfr_q      <= '0;
            dfr_flag_q <= 1'b0;
            crs_seen_q <= 1'b0;
        end else if (busy) begin
            if (coll_hit)
                coll_q <= coll_q + 1'b1;
            if (bit_stb && !deferring && frm_q != FW'(LATE_BITS))
                frm_q <= frm_q + 1'b1;
            if (bit_stb && deferring && dfr_q != TW'(DEFER_BITS))
                dfr_q <= dfr_q + 1'b1;
            if (ev_defer)
                dfr_flag_q <= 1'b1;
            if (carrier)
                crs_seen_q <= 1'b1;
        end
    end

endmodule

// File: rtl/tx_engine_fsm.sv
module tx_engine_fsm
    import tx_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_reset,
    input  logic start_dmd,
    input  logic bus_err,
    input  logic desc_fetch,
    input  logic desc_owned,
    output logic ev_buserr,
    output logic ev_desc,
    output logic halt,
    output logic stop
);
    eng_state_e st_q, st_d;

    always_comb begin
        ev_buserr = bus_err;
        ev_desc   = (st_q == ENG_RUN) && desc_fetch && !desc_owned && !bus_err;
    end

    always_comb begin
        st_d = st_q;
        if (sw_reset)
            st_d = ENG_RUN;
        else begin
            unique case (st_q)
                ENG_RUN: begin
                    if (bus_err)      st_d = ENG_HALT;
                    else if (ev_desc) st_d = ENG_STOP;
                end
                ENG_STOP: begin
                    if (bus_err)        st_d = ENG_HALT;
                    else if (start_dmd) st_d = ENG_RUN;
                end
                ENG_HALT: st_d = ENG_HALT;
                default:  st_d = ENG_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ENG_RUN;
        else
            st_q <= st_d;
    end

    // Output decode
    always_comb begin
        halt = (st_q == ENG_HALT);
        stop = (st_q == ENG_STOP);
    end

endmodule

// File: rtl/tx_evt_irq.sv
module tx_evt_irq
    import tx_evt_pkg::*;
#(
    parameter int unsigned ABORT_COLL = 16,
    parameter int unsigned LATE_BITS  = 512,
    parameter int unsigned DEFER_BITS = 32768,
    parameter int unsigned SLOW_DIV   = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_reset,
    input  logic        base_tick,
    input  logic        spd_10m,
    input  logic        pkt_start,
    input  logic        pkt_done,
    input  logic        collision,
    input  logic        carrier,
    input  logic        deferring,
    input  logic        fifo_underflow,
    input  logic        dma_fetch,
    input  logic        desc_owned,
    input  logic        dma_bus_err,
    input  logic        start_dmd_wr,
    input  logic        en_wr,
    input  logic        stat_clr_wr,
    input  logic [7:0]  wr_field,
    output logic [31:0] en_rdata,
    output logic [31:0] stat_rdata,
    output logic        irq,
    output logic        tx_halt,
    output logic        tx_stop
);
    localparam int unsigned HI_PAD = 32 - EVT_LO - EVT_N;

    logic     bit_stb;
    evt_vec_t evt;
    logic [EVT_N-1:0] en_q, st_q, clr_mask;

    tx_bit_pacer #(.SLOW_DIV(SLOW_DIV)) pacer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .spd_slow  (spd_10m),
        .bit_stb   (bit_stb)
    );

    tx_pkt_tracker #(
        .ABORT_COLL (ABORT_COLL),
        .LATE_BITS  (LATE_BITS),
        .DEFER_BITS (DEFER_BITS)
    ) trk_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .sw_reset       (sw_reset),
        .bit_stb        (bit_stb),
        .pkt_start      (pkt_start),
        .pkt_done       (pkt_done),
        .collision      (collision),
        .carrier        (carrier),
        .deferring      (deferring),
        .fifo_underflow (fifo_underflow),
        .ev_late        (evt.late),
        .ev_abort       (evt.abort),
        .ev_nocrs       (evt.nocrs),
        .ev_defer       (evt.defer),
        .ev_done        (evt.done),
        .ev_underrun    (evt.underrun)
    );

    tx_engine_fsm eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_reset   (sw_reset),
        .start_dmd  (start_dmd_wr),
        .bus_err    (dma_bus_err),
        .desc_fetch (dma_fetch),
        .desc_owned (desc_owned),
        .ev_buserr  (evt.bus_err),
        .ev_desc    (evt.desc),
        .halt       (tx_halt),
        .stop       (tx_stop)
    );

    always_comb clr_mask = stat_clr_wr ? wr_field : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (en_wr)
                en_q <= wr_field;
            st_q <= (st_q & ~clr_mask) | evt;
        end
    end

    always_comb begin
        en_rdata   = {{HI_PAD{1'b0}}, en_q, {EVT_LO{1'b0}}};
        stat_rdata = {{HI_PAD{1'b0}}, st_q, {EVT_LO{1'b0}}};
        irq        = |(st_q & en_q);
    end

endmodule

// File: rtl/tx_evt_irq_chk.sv
module tx_evt_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sw_reset,
    input logic        start_dmd_wr,
    input logic        dma_bus_err,
    input logic        stat_clr_wr,
    input logic [31:0] en_rdata,
    input logic [31:0] stat_rdata,
    input logic        irq,
    input logic        tx_halt,
    input logic        tx_stop
);
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_halt && !sw_reset |=> tx_halt); // R4

    AST_BUSERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        dma_bus_err && !sw_reset |=> tx_halt); // R4

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop && !start_dmd_wr && !sw_reset && !dma_bus_err |=> tx_stop); // R5

    AST_ENGINE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_halt, tx_stop})); // R4

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr_wr |=> ((stat_rdata & $past(stat_rdata)) == $past(stat_rdata))); // R2

    AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rdata == 32'd0) |-> !irq); // R3

endmodule

bind tx_evt_irq tx_evt_irq_chk chk_i (.*);

// File: tb/tx_evt_irq_tb.sv
module tx_evt_irq_tb_top;
    localparam int unsigned ABORT = 16;
    localparam int unsigned LATE  = 12;
    localparam int unsigned DEFER = 20;
    localparam int unsigned DIV   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_reset = 0, base_tick = 0, spd_10m = 0, pkt_start = 0, pkt_done = 0;
    logic collision = 0, carrier = 0, deferring = 0, fifo_underflow = 0;
    logic dma_fetch = 0, desc_owned = 1, dma_bus_err = 0, start_dmd_wr = 0;
    logic en_wr = 0, stat_clr_wr = 0;
    logic [7:0]  wr_field = '0;
    logic [31:0] en_rdata, stat_rdata;
    logic irq, tx_halt, tx_stop;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tx_evt_irq #(.ABORT_COLL(ABORT), .LATE_BITS(LATE), .DEFER_BITS(DEFER), .SLOW_DIV(DIV)) dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One rising edge, then strobes are cleared at the next falling edge
    task automatic step();
        @(negedge clk);
        {sw_reset, base_tick, pkt_start, pkt_done, collision, fifo_underflow,
         dma_fetch, dma_bus_err, start_dmd_wr, en_wr, stat_clr_wr} = '0;
    endtask

    task automatic clear_all();
        stat_clr_wr = 1; wr_field = 8'hFF; step();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin base_tick = 1; step(); end
    endtask

    function automatic logic sb(input int pos);
        return stat_rdata[pos];
    endfunction

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 en", en_rdata, 0);
        check("R1 stat", stat_rdata, 0);
        check("R1 outs", {29'd0, irq, tx_halt, tx_stop}, 0);

        // R6/R12 late collision sweep at both rates
        for (int s = 0; s < 2; s++) begin
            spd_10m = logic'(s);
            for (int k = 0; k <= int'(LATE) + 2; k++) begin
                clear_all();
                pkt_start = 1; step();
                carrier = 1;
                ticks(k * (s == 1 ? int'(DIV) : 1));
                collision = 1; step();
                check(s == 1 ? "R6 R12 late slow" : "R6 late fast", 32'(sb(22)), 32'(k >= int'(LATE)));
                pkt_done = 1; step();
                carrier = 0;
            end
        end
        // R12: one base tick short of LATE bit times at the slow rate
        clear_all();
        pkt_start = 1; step();
        ticks(int'(LATE * DIV) - 1);
        collision = 1; step();
        check("R12 slow short", 32'(sb(22)), 0);
        pkt_done = 1; step();
        spd_10m = 0; step();

        // R7/R10 collision count sweep
        for (int n = 1; n <= int'(ABORT) + 1; n++) begin
            clear_all();
            pkt_start = 1; step();
            for (int c = 0; c < n; c++) begin collision = 1; step(); end
            check("R7 abort", 32'(sb(21)), 32'(n >= int'(ABORT)));
            check("R10 done at abort", 32'(sb(18)), 32'(n >= int'(ABORT)));
            pkt_done = 1; step();
            check("R10 done", 32'(sb(18)), 1);
        end

        // R13 packet start resets collision count
        clear_all();
        pkt_start = 1; step();
        for (int c = 0; c < 10; c++) begin collision = 1; step(); end
        pkt_start = 1; step();
        for (int c = 0; c < 10; c++) begin collision = 1; step(); end
        check("R13 no abort", 32'(sb(21)), 0);
        pkt_done = 1; step();

        // R9 defer sweep
        for (int n = int'(DEFER) - 2; n <= int'(DEFER) + 2; n++) begin
            clear_all();
            pkt_start = 1; step();
            deferring = 1;
            ticks(n);
            deferring = 0;
            check("R9 defer", 32'(sb(19)), 32'(n > int'(DEFER)));
            pkt_done = 1; step();
        end

        // R8 no carrier
        clear_all();
        pkt_start = 1; step(); ticks(3);
        pkt_done = 1; step();
        check("R8 nocrs set", {sb(20), sb(18)}, 2'b11);
        clear_all();
        pkt_start = 1; step();
        carrier = 1; step(); carrier = 0; step();
        pkt_done = 1; step();
        check("R8 nocrs clear", {sb(20), sb(18)}, 2'b01);

        // R11 underflow only in packet
        clear_all();
        fifo_underflow = 1; step();
        check("R11 idle", 32'(sb(17)), 0);
        pkt_start = 1; step();
        fifo_underflow = 1; step();
        check("R11 busy", 32'(sb(17)), 1);
        pkt_done = 1; step();
        clear_all();
        fifo_underflow = 1; step();
        check("R11 after", 32'(sb(17)), 0);

        // R2 sticky and write-one-to-clear
        pkt_start = 1; step();
        fifo_underflow = 1; step();
        step(); step();
        check("R2 sticky", stat_rdata, 32'h1 << 17);
        stat_clr_wr = 1; wr_field = 8'h02; step();
        check("R2 other clear", stat_rdata, 32'h1 << 17);
        stat_clr_wr = 1; wr_field = 8'h01; fifo_underflow = 1; step();
        check("R2 set wins", stat_rdata, 32'h1 << 17);
        stat_clr_wr = 1; wr_field = 8'h01; step();
        check("R2 cleared", stat_rdata, 0);

        // R3 exhaustive enable sweep with only bit 17 set
        fifo_underflow = 1; step();
        for (int e = 0; e < 256; e++) begin
            en_wr = 1; wr_field = 8'(e); step();
            check("R3 irq", 32'(irq), 32'(e & 1));
            check("R3 en", en_rdata, 32'(e) << 17);
        end
        pkt_done = 1; step();
        en_wr = 1; wr_field = 8'h00; step();

        // R4 bus error halt
        clear_all();
        dma_bus_err = 1; step();
        check("R4 halt", {sb(24), tx_halt}, 2'b11);
        start_dmd_wr = 1; step();
        check("R4 start no release", 32'(tx_halt), 1);
        sw_reset = 1; step();
        check("R4 sw reset", {sb(24), tx_halt, tx_stop}, 3'b100);

        // R5 descriptor unavailable stop
        clear_all();
        desc_owned = 1; dma_fetch = 1; step();
        check("R5 owned", {sb(23), tx_stop}, 2'b00);
        desc_owned = 0; dma_fetch = 1; step();
        check("R5 stop", {sb(23), tx_stop}, 2'b11);
        step(); step();
        check("R5 holds", 32'(tx_stop), 1);
        start_dmd_wr = 1; step();
        check("R5 restart", {tx_stop, tx_halt}, 2'b00);
        desc_owned = 1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule